// File: doc/BRIEF.md
# Bitstream Input Fetch Engine

This block reads a compressed bitstream from main memory on behalf of a downstream decoder. Software programs a word-aligned start address and a byte count through a small register port. The engine then issues burst reads of 32-bit words and lands each burst in one of two 16-word local banks, used in alternation. The decoder pulls the words out through a valid/ready stream in the same order they were read from memory. As beats arrive, the address and count registers advance, so a read of either register shows the live fetch position.

Completion is reported through a sticky done flag that also drives the interrupt line. A programmable mode selects when the flag is set:

- **Mode 0:** on the same clock edge that the remaining count drops to zero.
- **Mode 1:** only once the count is zero, no burst is outstanding and both banks have been drained by the consumer.

A strobe bit in the control register decides what a control write touches. With the strobe set, the write loads a restart slice code into an internal register. With the strobe clear, the write changes the mode bit.

Top module: `bsin_dma`

## Requirements
- R1: After reset the address, count, mode, slice code and done flag are zero. `irq_o`, `mem_req_o` and `out_valid_o` are low.
- R2: Register select values are: 0 address, 1 byte count, 2 control, 3 status. Writes to the address and count registers force bits [1:0] to zero.
- R3: A read request is issued only when the next bank in fill order is completely empty and the count is non-zero. Its address equals the address register. Its length in words is 16 when at least 64 bytes remain, otherwise count/4. The address and length stay stable until `mem_gnt_i`.
- R4: Each accepted data beat raises the address register by 4 and lowers the count register by 4. Register reads return the live values.
- R5: The consumer receives every fetched word exactly once, in memory order, across both banks. `out_valid_o` is high only when unread data is present. The data is held while `out_ready_i` is low.
- R6: In mode 0 the done flag rises on the edge where the count becomes zero, even while the banks still hold unread words.
- R7: In mode 1 the done flag stays low until the count is zero, no burst is in flight and both banks are empty.
- R8: `irq_o` follows the done flag. The flag is sticky. Writing 1 to status bit 0 clears it, and writing 0 has no effect.
- R9: Writing a non-zero count re-arms done detection for a new transfer. Writing a zero count starts no fetch and never sets done.
- R10: Control layout: bit 0 is the mode, bits [15:8] the slice code, bit 16 the strobe. With the strobe at 1, only the slice code is loaded and appears on `slice_code_o`. With the strobe at 0, only the mode is updated. Bit 16 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| mem_req_o | output | 1 | Burst read request |
| mem_addr_o | output | 32 | Burst start byte address |
| mem_len_o | output | 5 | Burst length in words |
| mem_gnt_i | input | 1 | Request accepted |
| mem_valid_i | input | 1 | Read data beat valid |
| mem_rdata_i | input | 32 | Read data beat |
| out_valid_o | output | 1 | Stream word available |
| out_data_o | output | 32 | Stream word |
| out_ready_i | input | 1 | Consumer takes the word |
| slice_code_o | output | 8 | Stored restart slice code |
| done_o | output | 1 | Sticky done flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is mode 1 with the count already at zero while words are still parked in a bank. The flag must stay low there, yet a fast consumer empties the banks within a few cycles. The stimulus holds the consumer off until both banks are full and fetching has stalled. It then lets it run at a random rate, and freezes it again on the first cycle the count reads zero, so the remaining words stay buffered while the flag is sampled. The same holding technique exposes the mode 0 edge, where done must coincide with the count reaching zero while data is still unread.

// File: rtl/bsin_pkg.sv
package bsin_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    REG_ADDR  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_MODE_BIT   = 0;
  localparam int unsigned CTRL_CODE_LSB   = 8;
  localparam int unsigned CTRL_STROBE_BIT = 16;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_DATA = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/bsin_regs.sv
module bsin_regs
  import bsin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             beat_i,
  input  logic             fetch_idle_i,
  input  logic             bufs_empty_i,
  output logic [REG_W-1:0] addr_o,
  output logic [REG_W-1:0] cnt_o,
  output logic             mode_o,
  output logic [7:0]       code_o,
  output logic             done_o
);
  logic [REG_W-1:0] addr_q, cnt_q;
  logic             mode_q, armed_q, done_q;
  logic [7:0]       code_q;
  logic             wr_addr, wr_cnt, wr_ctrl, wr_stat, set_done, clr_done;
  logic             unused_wbit;

  assign wr_addr  = we_i && (sel_i == REG_ADDR);
  assign wr_cnt   = we_i && (sel_i == REG_COUNT);
  assign wr_ctrl  = we_i && (sel_i == REG_CTRL);
  assign wr_stat  = we_i && (sel_i == REG_STAT);
  assign clr_done = wr_stat && wdata_i[0];
  assign unused_wbit = wdata_i[1];

  // mode 1 waits for drain, mode 0 fires on the last beat
  assign set_done = armed_q && (mode_q ? (cnt_q == '0 && fetch_idle_i && bufs_empty_i)
                                       : (beat_i && cnt_q == REG_W'(4)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      if (wr_addr)     addr_q <= {wdata_i[REG_W-1:2], 2'b00};
      else if (beat_i) addr_q <= addr_q + REG_W'(4);

      if (wr_cnt) begin
        cnt_q   <= {wdata_i[REG_W-1:2], 2'b00};
        armed_q <= |wdata_i[REG_W-1:2];
      end else begin
        if (beat_i)   cnt_q   <= cnt_q - REG_W'(4);
        if (set_done) armed_q <= 1'b0;
      end

      if (set_done)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;

      if (wr_ctrl) begin
        if (wdata_i[CTRL_STROBE_BIT]) code_q <= wdata_i[CTRL_CODE_LSB +: 8];
        else                          mode_q <= wdata_i[CTRL_MODE_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      REG_ADDR:  rdata_o = addr_q;
      REG_COUNT: rdata_o = cnt_q;
      REG_CTRL: begin
        rdata_o[CTRL_MODE_BIT]        = mode_q;
        rdata_o[CTRL_CODE_LSB +: 8]   = code_q;
      end
      default:   rdata_o[0] = done_q;
    endcase
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign code_o = code_q;
  assign done_o = done_q;

  p_beat_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> cnt_q != '0);
  p_clear_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_done) |=> done_q);
endmodule

// File: rtl/bsin_fetch.sv
module bsin_fetch
  import bsin_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 16,
  localparam int unsigned LW = $clog2(BUF_WORDS + 1),
  localparam int unsigned IW = $clog2(BUF_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] addr_i,
  input  logic [REG_W-1:0] cnt_i,
  input  logic [1:0]       bank_empty_i,
  output logic             mem_req_o,
  output logic [REG_W-1:0] mem_addr_o,
  output logic [LW-1:0]    mem_len_o,
  input  logic             mem_gnt_i,
  input  logic             mem_valid_i,
  output logic             beat_o,
  output logic             fill_o,
  output logic             wr_sel_o,
  output logic [IW-1:0]    wr_idx_o,
  output logic [LW-1:0]    fill_len_o,
  output logic             idle_o
);
  fetch_state_e     state_q;
  logic             sel_q;
  logic [LW-1:0]    len_q, beat_q, len_d;
  logic [REG_W-3:0] words;
  logic             last_beat;
  logic [1:0]       unused_cnt;

  assign words      = cnt_i[REG_W-1:2];
  assign unused_cnt = cnt_i[1:0];
  assign len_d      = (words >= (REG_W-2)'(BUF_WORDS)) ? LW'(BUF_WORDS) : words[LW-1:0];
  assign beat_o     = (state_q == FS_DATA) && mem_valid_i;
  assign last_beat  = beat_o && (beat_q + LW'(1) == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      sel_q   <= 1'b0;
      len_q   <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (cnt_i != '0 && bank_empty_i[sel_q]) begin
          len_q   <= len_d;
          beat_q  <= '0;
          state_q <= FS_REQ;
        end
        FS_REQ: if (mem_gnt_i) state_q <= FS_DATA;
        FS_DATA: if (beat_o) begin
          beat_q <= beat_q + LW'(1);
          if (last_beat) begin
            sel_q   <= ~sel_q;
            state_q <= FS_IDLE;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == FS_REQ);
  assign mem_addr_o = addr_i;
  assign mem_len_o  = len_q;
  assign fill_o     = last_beat;
  assign wr_sel_o   = sel_q;
  assign wr_idx_o   = beat_q[IW-1:0];
  assign fill_len_o = len_q;
  assign idle_o     = (state_q == FS_IDLE);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o));
  p_len_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != '0 && mem_len_o <= LW'(BUF_WORDS)));
  p_req_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

// File: rtl/bsin_buf.sv
module bsin_buf #(
  parameter int unsigned BUF_WORDS = 16,
  parameter int unsigned DW        = 32,
  localparam int unsigned LW = $clog2(BUF_WORDS + 1),
  localparam int unsigned IW = $clog2(BUF_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          fill_i,
  input  logic [LW-1:0] fill_len_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  input  logic          out_ready_i,
  output logic [1:0]    empty_o
);
  logic          rd_sel_q;
  logic          pop;
  logic [1:0]    last_w;
  logic [DW-1:0] word [2];

  assign pop = out_valid_o && out_ready_i;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] store_q [BUF_WORDS];
    logic [LW-1:0] lvl_q;
    logic [IW-1:0] ptr_q;
    logic          mine_wr, mine_rd;

    assign mine_wr = (wr_sel_i == 1'(b));
    assign mine_rd = (rd_sel_q == 1'(b));

    always_ff @(posedge clk_i) begin
      if (wr_en_i && mine_wr) store_q[wr_idx_i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q <= '0;
        ptr_q <= '0;
      end else if (fill_i && mine_wr) begin
        lvl_q <= fill_len_i;
        ptr_q <= '0;
      end else if (pop && mine_rd) begin
        if (last_w[b]) begin
          lvl_q <= '0;
          ptr_q <= '0;
        end else begin
          ptr_q <= ptr_q + IW'(1);
        end
      end
    end

    assign last_w[b]  = (LW'(ptr_q) + LW'(1) == lvl_q);
    assign empty_o[b] = (lvl_q == '0);
    assign word[b]    = store_q[ptr_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rd_sel_q <= 1'b0;
    else if (pop && last_w[rd_sel_q]) rd_sel_q <= ~rd_sel_q;
  end

  assign out_valid_o = !empty_o[rd_sel_q];
  assign out_data_o  = word[rd_sel_q];

  p_fill_into_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> empty_o[wr_sel_i]);
  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o));
endmodule

// File: rtl/bsin_dma.sv
module bsin_dma
  import bsin_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             reg_we_i,
  input  logic [1:0]                       reg_sel_i,
  input  logic [31:0]                      reg_wdata_i,
  output logic [31:0]                      reg_rdata_o,
  output logic                             mem_req_o,
  output logic [31:0]                      mem_addr_o,
  output logic [$clog2(BUF_WORDS+1)-1:0]   mem_len_o,
  input  logic                             mem_gnt_i,
  input  logic                             mem_valid_i,
  input  logic [31:0]                      mem_rdata_i,
  output logic                             out_valid_o,
  output logic [31:0]                      out_data_o,
  input  logic                             out_ready_i,
  output logic [7:0]                       slice_code_o,
  output logic                             done_o,
  output logic                             irq_o
);
  localparam int unsigned LW = $clog2(BUF_WORDS + 1);
  localparam int unsigned IW = $clog2(BUF_WORDS);

  logic [REG_W-1:0] cur_addr, cur_cnt;
  logic             mode, beat, fill, wr_sel, fetch_idle;
  logic [IW-1:0]    wr_idx;
  logic [LW-1:0]    fill_len;
  logic [1:0]       bank_empty;

  bsin_regs i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .sel_i        (reg_sel_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .beat_i       (beat),
    .fetch_idle_i (fetch_idle),
    .bufs_empty_i (&bank_empty),
    .addr_o       (cur_addr),
    .cnt_o        (cur_cnt),
    .mode_o       (mode),
    .code_o       (slice_code_o),
    .done_o       (done_o)
  );

  bsin_fetch #(.BUF_WORDS(BUF_WORDS)) i_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (cur_addr),
    .cnt_i        (cur_cnt),
    .bank_empty_i (bank_empty),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_len_o    (mem_len_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_valid_i  (mem_valid_i),
    .beat_o       (beat),
    .fill_o       (fill),
    .wr_sel_o     (wr_sel),
    .wr_idx_o     (wr_idx),
    .fill_len_o   (fill_len),
    .idle_o       (fetch_idle)
  );

  bsin_buf #(.BUF_WORDS(BUF_WORDS), .DW(32)) i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (beat),
    .wr_sel_i    (wr_sel),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (mem_rdata_i),
    .fill_i      (fill),
    .fill_len_i  (fill_len),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .empty_o     (bank_empty)
  );

  assign irq_o = done_o;

  p_done_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cur_cnt == '0);
  p_done_drained_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && $past(mode)) |-> $past(&bank_empty) && $past(fetch_idle));
endmodule

// File: tb/test_bsin_dma.sv
`timescale 1ns/1ps
module test_bsin_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [4:0]  mem_len;
  logic        mem_gnt = 1'b0;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b0;
  logic [7:0]  slice_code;
  logic        done, irq;

  int checks = 0;
  int errors = 0;
  bit hold = 1'b1;
  int rdy_pct = 70;
  logic [31:0] exp_fetch_addr, exp_fetch_rem, exp_rd_addr;
  int rcv = 0;
  int b_left = 0;
  logic [31:0] b_addr = '0;

  always #2 clk = ~clk;

  bsin_dma i_bsin_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_gnt_i(mem_gnt), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .slice_code_o(slice_code), .done_o(done), .irq_o(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] exp_len(input logic [31:0] rem);
    return (rem >= 32'd64) ? 32'd16 : rem >> 2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic start_xfer(input logic [31:0] a, input logic [31:0] bytes);
    exp_fetch_addr = a; exp_fetch_rem = bytes; exp_rd_addr = a; rcv = 0;
    reg_wr(2'd0, a);
    reg_wr(2'd1, bytes);
  endtask

  task automatic wait_cnt_zero(input int bound);
    logic [31:0] v;
    for (int i = 0; i < bound; i++) begin
      reg_rd(2'd1, v);
      if (v == 0) break;
      tick();
    end
  endtask

  task automatic wait_done(input int bound);
    for (int i = 0; i < bound; i++) begin
      if (done) break;
      tick();
    end
  endtask

  task automatic wait_rcv(input int n, input int bound);
    for (int i = 0; i < bound; i++) begin
      if (rcv >= n) break;
      tick();
    end
  endtask

  // memory responder
  initial forever begin
    @(negedge clk);
    if (mem_valid) begin b_addr += 4; b_left--; end
    mem_valid = 1'b0;
    mem_gnt = 1'b0;
    if (b_left > 0) begin
      if ($urandom % 4 != 0) begin mem_valid = 1'b1; mem_rdata = pat(b_addr); end
    end else if (rst_n && mem_req && ($urandom % 3 == 0)) begin
      chk("R3 request address", mem_addr, exp_fetch_addr);
      chk("R3 request length", 32'(mem_len), exp_len(exp_fetch_rem));
      mem_gnt = 1'b1;
      b_left = int'(mem_len);
      b_addr = mem_addr;
      exp_fetch_addr += 32'(mem_len) * 4;
      exp_fetch_rem  -= 32'(mem_len) * 4;
    end
  end

  // consumer
  initial forever begin
    @(negedge clk);
    out_ready = rst_n && !hold && (($urandom % 100) < rdy_pct);
    if (out_ready && out_valid) begin
      chk("R5 stream word", out_data, pat(exp_rd_addr));
      exp_rd_addr += 4;
      rcv++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    // R1 reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    tick();
    reg_rd(2'd0, v); chk("R1 address", v, 0);
    reg_rd(2'd1, v); chk("R1 count", v, 0);
    reg_rd(2'd2, v); chk("R1 control", v, 0);
    chk("R1 slice code", 32'(slice_code), 0);

    // R10 strobe selects target field
    reg_wr(2'd2, 32'h0001_5A01);
    chk("R10 slice loaded", 32'(slice_code), 32'h5A);
    reg_rd(2'd2, v);
    chk("R10 mode untouched by strobe write", 32'(v[0]), 0);
    chk("R10 strobe reads zero", 32'(v[16]), 0);
    chk("R10 code readback", 32'(v[15:8]), 32'h5A);
    reg_wr(2'd2, 32'h0000_FF01);
    reg_rd(2'd2, v);
    chk("R10 mode set", 32'(v[0]), 1);
    chk("R10 slice kept", 32'(slice_code), 32'h5A);
    reg_wr(2'd2, 32'h0000_0000);

    // R2 alignment forcing
    reg_wr(2'd0, 32'h0000_1003);
    reg_rd(2'd0, v); chk("R2 address aligned", v, 32'h0000_1000);
    reg_wr(2'd1, 32'h0000_0000);

    // R6 mode 0, consumer held
    hold = 1'b1;
    start_xfer(32'h0000_1000, 32'd40);
    wait_cnt_zero(500);
    reg_rd(2'd1, v); chk("R6 count reached zero", v, 0);
    chk("R6 done with count zero", 32'(done), 1);
    chk("R6 data still buffered", 32'(out_valid), 1);
    chk("R8 irq follows done", 32'(irq), 1);
    reg_rd(2'd0, v); chk("R4 address advanced", v, 32'h0000_1028);
    hold = 1'b0;
    wait_rcv(10, 1000);
    chk("R5 words received", 32'(rcv), 10);
    tick();
    chk("R5 no valid when empty", 32'(out_valid), 0);

    // R8 sticky, W1C
    reg_wr(2'd3, 32'h0);
    chk("R8 write 0 keeps done", 32'(done), 1);
    reg_wr(2'd3, 32'h1);
    chk("R8 write 1 clears done", 32'(done), 0);
    chk("R8 irq cleared", 32'(irq), 0);

    // R9 zero count
    reg_wr(2'd1, 32'h0);
    repeat (20) tick();
    chk("R9 zero count no done", 32'(done), 0);
    chk("R9 zero count no request", 32'(mem_req), 0);

    // R7 mode 1 drain condition
    reg_wr(2'd2, 32'h0000_0001);
    hold = 1'b1;
    start_xfer(32'h0000_4000, 32'd200);
    repeat (300) tick();
    reg_rd(2'd1, v); chk("R3 fetch stops with both banks full", v, 32'd72);
    reg_rd(2'd0, v); chk("R4 address after two bursts", v, 32'h0000_4080);
    chk("R3 no request while full", 32'(mem_req), 0);
    chk("R7 no done while fetching", 32'(done), 0);
    hold = 1'b0;
    wait_cnt_zero(2000);
    hold = 1'b1;
    reg_rd(2'd1, v); chk("R7 count zero reached", v, 0);
    chk("R7 done low with data buffered", 32'(done), 0);
    repeat (40) tick();
    chk("R7 done still low while held", 32'(done), 0);
    chk("R7 data still buffered", 32'(out_valid), 1);
    hold = 1'b0;
    wait_done(2000);
    chk("R7 done after drain", 32'(done), 1);
    chk("R5 all words delivered", 32'(rcv), 50);
    chk("R7 banks empty at done", 32'(out_valid), 0);

    // R9 re-arm with new count
    reg_wr(2'd3, 32'h1);
    start_xfer(32'h0000_8000, 32'd8);
    wait_done(2000);
    chk("R9 re-armed done", 32'(done), 1);
    chk("R9 words received", 32'(rcv), 2);

    // random transfers
    for (int r = 0; r < 8; r++) begin
      logic [31:0] a, n;
      bit m;
      a = {12'h0, 20'($urandom)} & 32'hFFFF_FFFC;
      n = 32'(4 * (1 + ($urandom % 100)));
      m = 1'($urandom % 2);
      rdy_pct = 20 + int'($urandom % 80);
      reg_wr(2'd3, 32'h1);
      reg_wr(2'd2, {31'h0, m});
      start_xfer(a, n);
      wait_done(8000);
      chk(m ? "R7 random done" : "R6 random done", 32'(done), 1);
      wait_rcv(int'(n >> 2), 8000);
      chk("R5 random word count", 32'(rcv), n >> 2);
      reg_rd(2'd0, v); chk("R4 random final address", v, a + n);
      reg_rd(2'd1, v); chk("R4 random final count", v, 0);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule